// File: doc/BRIEF.md
# Latched BCD Seven-Segment Liquid-Crystal Digit Driver

This block turns a four-bit BCD digit into the seven segment drive lines a through g of one display digit. A capture register sits in front of the decoder. While the load enable is high, the register follows the input digit. While the enable is low, it keeps the last digit it loaded. An active-high blank input turns every segment off. Input codes above nine also blank the digit, so they never show letters.

Liquid-crystal glass must never see a DC voltage. For that reason, all seven segment outputs are XORed with a phase signal, and the same phase leaves the block on a backplane output. A lit segment is therefore always opposite to the backplane and an unlit one always equal to it. The phase comes from an external pin or from an internal divider that makes a 50 percent square wave. The segment lines and the backplane line are registered on the same clock edge, so they switch together.

The design runs on one clock. It has an asynchronous active-low reset whose release is synchronised inside the block. A digit applied with the enable high reaches the segment pins two clock edges later: one edge for the capture and one for the output register.

Top module: `lcd_digit_driver`

## Requirements
- R1: While `load_en` is high, each rising clock edge captures `bcd_in`. The segments show the pattern for that digit after the second rising edge following the input change.
- R2: While `load_en` is low, changes on `bcd_in` have no effect. The segments keep showing the digit captured on the last edge at which `load_en` was high.
- R3: When `blank` is high, all segments are unlit one rising edge later, whatever digit is stored.
- R4: Stored codes 10 to 15 give an unlit digit, the same as `blank`.
- R5: `seg[0]` is segment a (top), `seg[1]` is b (upper right), `seg[2]` is c (lower right), `seg[3]` is d (bottom), `seg[4]` is e (lower left), `seg[5]` is f (upper left) and `seg[6]` is g (middle). The lit segments are: 0 = abcdef, 1 = bc, 2 = abdeg, 3 = abcdg, 4 = bcfg, 5 = acdfg, 6 = acdefg, 7 = abc, 8 = all seven, 9 = abcdfg.
- R6: With the selected phase low, a lit segment drives 1 and an unlit segment drives 0. With the phase high, all seven outputs are inverted, and this includes a blanked digit.
- R7: `backplane` equals the selected phase registered on the same edge as `seg`. A change on `phase_ext` therefore appears on both outputs one rising edge later when `phase_sel_int` is low.
- R8: When `phase_sel_int` is high, the phase comes from an internal divider. The divider toggles once every `HALF_PERIOD` clocks, giving a 50 percent duty cycle.
- R9: While `rst_n` is low, `seg` and `backplane` are 0, the stored digit is 0 and the internal phase is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bcd_in | input | 4 | BCD digit to display |
| load_en | input | 1 | High: register follows `bcd_in`; low: register holds |
| blank | input | 1 | High turns all segments off |
| phase_ext | input | 1 | External backplane square wave |
| phase_sel_int | input | 1 | High selects the internal divider phase |
| seg | output | 7 | Segment drives, bit 0 = a through bit 6 = g |
| backplane | output | 1 | Selected phase, aligned with `seg` |

## Verification
The assertions assume that the inputs are synchronous to `clk` and are stable at each rising edge. The hold and capture properties only apply after at least one cycle out of the synchronised reset. The bench changes every input on the falling edge and samples the outputs on a later falling edge, so each value is settled a half period before the edge that uses it. The stimulus stays inside these assumptions. It covers all sixteen codes under both phases, blanking, holding, and a run long enough to see several half periods of the internal divider.

// File: rtl/seg_lcd_pkg.sv
package seg_lcd_pkg;
  localparam int DIGIT_W = 4;
  localparam int SEG_N   = 7;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [SEG_N-1:0]   seg_vec_t;

  // Lit-segment set for a code; bit 0 = a ... bit 6 = g; non-decimal codes dark
  function automatic seg_vec_t glyph(input digit_t code);
    seg_vec_t lit;
    case (code)
      4'd0:    lit = 7'b0111111;
      4'd1:    lit = 7'b0000110;
      4'd2:    lit = 7'b1011011;
      4'd3:    lit = 7'b1001111;
      4'd4:    lit = 7'b1100110;
      4'd5:    lit = 7'b1101101;
      4'd6:    lit = 7'b1111101;
      4'd7:    lit = 7'b0000111;
      4'd8:    lit = 7'b1111111;
      4'd9:    lit = 7'b1101111;
      default: lit = '0;
    endcase
    return lit;
  endfunction
endpackage

// File: rtl/reset_release_sync.sv
module reset_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/digit_hold_reg.sv
module digit_hold_reg
  import seg_lcd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_en,
  input  digit_t d_in,
  output digit_t d_q
);
  digit_t d_next;

  always_comb begin
    d_next = d_q;
    if (load_en) d_next = d_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_q <= '0;
    else        d_q <= d_next;
  end
endmodule

// File: rtl/segment_encoder.sv
module segment_encoder
  import seg_lcd_pkg::*;
(
  input  digit_t   digit,
  input  logic     blank,
  input  logic     phase,
  output seg_vec_t drive
);
  seg_vec_t lit;

  always_comb begin
    lit   = blank ? '0 : glyph(digit);
    drive = lit ^ {SEG_N{phase}};
  end
endmodule

// File: rtl/backplane_divider.sv
module backplane_divider #(
  parameter int HALF_PERIOD = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase
);
  localparam int CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_PERIOD - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ph_q, ph_d;
  logic             wrap;

  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    ph_d  = ph_q;
    if (wrap) ph_d = ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign phase = ph_q;
endmodule

// File: rtl/lcd_digit_driver.sv
module lcd_digit_driver
  import seg_lcd_pkg::*;
#(
  parameter int HALF_PERIOD = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] bcd_in,
  input  logic       load_en,
  input  logic       blank,
  input  logic       phase_ext,
  input  logic       phase_sel_int,
  output logic [6:0] seg,
  output logic       backplane
);
  logic     rst_sync_n;
  digit_t   stored_q;
  logic     phase_int;
  logic     phase_pick;
  seg_vec_t seg_next;
  seg_vec_t seg_q;
  logic     bp_q;

  reset_release_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  digit_hold_reg i_hold (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_en (load_en),
    .d_in    (bcd_in),
    .d_q     (stored_q)
  );

  backplane_divider #(.HALF_PERIOD(HALF_PERIOD)) i_div (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .phase (phase_int)
  );

  always_comb begin
    phase_pick = phase_sel_int ? phase_int : phase_ext;
  end

  segment_encoder i_enc (
    .digit (stored_q),
    .blank (blank),
    .phase (phase_pick),
    .drive (seg_next)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      seg_q <= '0;
      bp_q  <= 1'b0;
    end else begin
      seg_q <= seg_next;
      bp_q  <= phase_pick;
    end
  end

  assign seg       = seg_q;
  assign backplane = bp_q;
endmodule

// File: rtl/lcd_digit_driver_chk.sv
module lcd_digit_driver_chk (
  input logic       clk,
  input logic       srst_n,
  input logic [3:0] bcd_in,
  input logic       load_en,
  input logic       blank,
  input logic       phase_ext,
  input logic       phase_sel_int,
  input logic [3:0] stored_q,
  input logic [6:0] seg,
  input logic       backplane
);
  // R1: transparent capture
  a_r1_capture: assert property (@(posedge clk) disable iff (!srst_n)
    ($past(srst_n) && $past(load_en)) |-> (stored_q == $past(bcd_in)));

  // R2: hold while enable low
  a_r2_hold: assert property (@(posedge clk) disable iff (!srst_n)
    ($past(srst_n) && !$past(load_en)) |-> $stable(stored_q));

  // R3 and R6: blank gives segments equal to the backplane
  a_r3_blank_dark: assert property (@(posedge clk) disable iff (!srst_n)
    ($past(srst_n) && $past(blank)) |-> (seg == {7{backplane}}));

  // R4: non-decimal codes dark
  a_r4_invalid_dark: assert property (@(posedge clk) disable iff (!srst_n)
    ($past(srst_n) && ($past(stored_q) > 4'd9)) |-> (seg == {7{backplane}}));

  // R5: a decimal digit lights at least one segment
  a_r5_digit_lit: assert property (@(posedge clk) disable iff (!srst_n)
    ($past(srst_n) && ($past(stored_q) <= 4'd9) && !$past(blank))
      |-> (seg != {7{backplane}}));

  // R7: backplane follows external phase one edge later
  a_r7_bp_ext: assert property (@(posedge clk) disable iff (!srst_n)
    ($past(srst_n) && !$past(phase_sel_int)) |-> (backplane == $past(phase_ext)));
endmodule

bind lcd_digit_driver lcd_digit_driver_chk i_chk (
  .clk           (clk),
  .srst_n        (rst_sync_n),
  .bcd_in        (bcd_in),
  .load_en       (load_en),
  .blank         (blank),
  .phase_ext     (phase_ext),
  .phase_sel_int (phase_sel_int),
  .stored_q      (stored_q),
  .seg           (seg),
  .backplane     (backplane)
);

// File: tb/test_lcd_digit_driver.sv
`timescale 1ns/1ps
module test_lcd_digit_driver;
  localparam time CLK_PERIOD = 10ns;
  localparam int  HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] bcd_in;
  logic       load_en, blank, phase_ext, phase_sel_int;
  logic [6:0] seg;
  logic       backplane;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_digit_driver #(.HALF_PERIOD(HALF)) i_lcd_digit_driver (
    .clk(clk), .rst_n(rst_n), .bcd_in(bcd_in), .load_en(load_en),
    .blank(blank), .phase_ext(phase_ext), .phase_sel_int(phase_sel_int),
    .seg(seg), .backplane(backplane)
  );

  // Lit sets from R5, bit 0 = a ... bit 6 = g
  function automatic logic [6:0] lit_of(input int d);
    case (d)
      0: return 7'b0111111;  // abcdef
      1: return 7'b0000110;  // bc
      2: return 7'b1011011;  // abdeg
      3: return 7'b1001111;  // abcdg
      4: return 7'b1100110;  // bcfg
      5: return 7'b1101101;  // acdfg
      6: return 7'b1111101;  // acdefg
      7: return 7'b0000111;  // abc
      8: return 7'b1111111;
      9: return 7'b1101111;  // abcdfg
      default: return 7'b0000000;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; bcd_in = 4'd8; load_en = 1'b1; blank = 1'b0;
    phase_ext = 1'b1; phase_sel_int = 1'b0;
    step(3);
    check("R9 reset seg", {1'b0, seg}, 8'h00);
    check("R9 reset backplane", {7'b0, backplane}, 8'h00);
    rst_n = 1'b1;
    phase_ext = 1'b0; load_en = 1'b0;
    step(4);
    check("R9 stored digit zero after reset", {1'b0, seg}, {1'b0, lit_of(0)});
  endtask

  task automatic t_digits(input logic ph);
    for (int d = 0; d < 16; d++) begin
      bcd_in = 4'(d); load_en = 1'b1; blank = 1'b0; phase_ext = ph;
      step(2);
      if (d <= 9)
        check(ph ? "R6 inverted digit" : "R1 R5 digit", {1'b0, seg}, {1'b0, lit_of(d) ^ {7{ph}}});
      else
        check(ph ? "R4 R6 invalid dark inverted" : "R4 invalid dark", {1'b0, seg}, {1'b0, {7{ph}}});
    end
  endtask

  task automatic t_blank;
    bcd_in = 4'd8; load_en = 1'b1; blank = 1'b0; phase_ext = 1'b0;
    step(2);
    blank = 1'b1;
    step(1);
    check("R3 blank after one edge", {1'b0, seg}, 8'h00);
    phase_ext = 1'b1;
    step(1);
    check("R6 blank inverted", {1'b0, seg}, 8'h7F);
    check("R7 backplane follows", {7'b0, backplane}, 8'h01);
    blank = 1'b0;
    step(1);
    check("R3 unblank", {1'b0, seg}, {1'b0, ~lit_of(8)});
  endtask

  task automatic t_hold;
    phase_ext = 1'b0; blank = 1'b0;
    bcd_in = 4'd5; load_en = 1'b1;
    step(1);
    load_en = 1'b0; bcd_in = 4'd3;
    step(2);
    check("R2 hold after change", {1'b0, seg}, {1'b0, lit_of(5)});
    bcd_in = 4'd12;
    step(3);
    check("R2 hold ignores invalid", {1'b0, seg}, {1'b0, lit_of(5)});
    load_en = 1'b1;
    step(2);
    check("R1 reopen follows", {1'b0, seg}, 8'h00);
  endtask

  task automatic t_internal;
    int run;
    int runs_ok;
    logic prev;
    bcd_in = 4'd2; load_en = 1'b1; blank = 1'b0; phase_ext = 1'b0;
    phase_sel_int = 1'b1;
    step(2);
    prev = backplane; run = 0; runs_ok = 1;
    for (int i = 0; i < 6 * HALF; i++) begin
      step(1);
      check("R6 R8 seg tracks internal phase", {1'b0, seg}, {1'b0, lit_of(2) ^ {7{backplane}}});
      if (backplane != prev) begin
        if (run > 0) check("R8 half period", 8'(run), 8'(HALF));
        run = 1; prev = backplane;
      end else if (run > 0) run++;
    end
    phase_sel_int = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++; checks++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_digits(1'b0);
    t_digits(1'b1);
    t_blank();
    t_hold();
    t_internal();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule